// File: doc/BRIEF.md
# Embedded Timing Reference Decoder

The block watches a multiplexed 4:2:2 component video byte stream, one byte per clock, and finds the in-band timing reference codes. Each code is three fixed preamble bytes (all ones, all zeros, all zeros) followed by a status byte. The status byte carries the field, vertical-blanking and horizontal flags, protected by four check bits. From accepted codes the block recovers line and frame timing. No separate sync pins are needed.

Outputs are registered H, V and F flags, a blanking level, an active-video strobe and a sample-phase index (Cb, Y, Cr, Y) for active bytes. A one-clock error pulse reports a status byte whose protection does not check. All outputs describe the byte sampled at the previous rising clock edge. Each output therefore lags the input by exactly one cycle.

Top module: `tref_decoder`

## Requirements
- R1: While rst_ni is low, every output is 0, and the detector forgets any partial preamble.
- R2: A byte is taken as a status byte only when the three bytes sampled just before it were 0xFF, 0x00, 0x00. A status byte is accepted when bit7 is 1 and bits 3..0 equal {V^H, F^H, F^V, F^V^H}, where F is bit6, V is bit5 and H is bit4. On acceptance, f_o, v_o and h_o take those bits one cycle after the byte is sampled.
- R3: A status byte that fails the check in R2 raises err_o for exactly one cycle and leaves h_o, v_o and f_o unchanged. A byte with bit7 = 0 also fails, even when its check bits are right.
- R4: A broken preamble (any other byte where 0x00 is due) makes the byte after it an ordinary byte. No flag changes and no error is raised.
- R5: An accepted status byte with H = 0 and V = 0 starts a line. active_o is high, one cycle late, for every following byte until a 0xFF byte is sampled. A line of 1440 data bytes gives 1440 active cycles.
- R6: A start code with V = 1, a code with H = 1, or a rejected code never raises active_o.
- R7: While active_o is high, phase_o runs 0,1,2,3,0,… (0 = Cb, 1 = Y, 2 = Cr, 3 = Y), starting at 0 on the first byte after each start code. phase_o is 0 while active_o is low.
- R8: blank_o equals h_o OR v_o.
- R9: Extra 0xFF bytes before the two 0x00 bytes still form a valid preamble.
- R10: Filler bytes 0x80 and 0x10 in horizontal blanking leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Multiplexed video byte |
| h_o | output | 1 | Horizontal flag of last accepted code |
| v_o | output | 1 | Vertical blanking flag of last accepted code |
| f_o | output | 1 | Field flag of last accepted code |
| blank_o | output | 1 | Blanking level, h_o OR v_o |
| active_o | output | 1 | Previous byte was an active sample |
| phase_o | output | PHASE_W | Sample position of the previous active byte |
| err_o | output | 1 | Previous byte was a rejected status byte |

## Verification
The bench builds the block with the defaults DATA_W = 8 and PH_N = 4. It sends full 1440-byte lines, so phase wraps many times per line and the active count covers a whole line. Random line codes mix field and blanking values with corrupted check bits and broken preambles. Directed cases add a repeated preamble byte, a status byte with bit7 cleared, and a reset in the middle of a line.

// File: rtl/tref_pkg.sv
package tref_pkg;
  typedef enum logic [1:0] {
    DET_SEARCH = 2'd0,
    DET_ONES   = 2'd1,
    DET_ZERO1  = 2'd2,
    DET_ZERO2  = 2'd3
  } det_state_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } tref_flags_t;
endpackage

// File: rtl/tref_preamble_det.sv
module tref_preamble_det #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              status_stb_o,
  output logic              ones_o
);
  import tref_pkg::*;

  localparam logic [DATA_W-1:0] ALL_ONES  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ALL_ZEROS = {DATA_W{1'b0}};

  det_state_e state_q, state_d;
  logic       is_zero;

  assign ones_o       = (data_i == ALL_ONES);
  assign is_zero      = (data_i == ALL_ZEROS);
  assign status_stb_o = (state_q == DET_ZERO2);

  always_comb begin
    state_d = DET_SEARCH;
    if (ones_o) begin
      state_d = DET_ONES;
    end else begin
      unique case (state_q)
        DET_ONES:  if (is_zero) state_d = DET_ZERO1;
        DET_ZERO1: if (is_zero) state_d = DET_ZERO2;
        default:   state_d = DET_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DET_SEARCH;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/tref_status_chk.sv
module tref_status_chk #(
  parameter int DATA_W = 8
) (
  input  logic                  [DATA_W-1:0] data_i,
  output tref_pkg::tref_flags_t              flags_o,
  output logic                               ok_o
);
  localparam int LSB = DATA_W - 8;

  logic [3:0] prot_exp;
  logic [3:0] prot_got;

  assign flags_o.f = data_i[LSB+6];
  assign flags_o.v = data_i[LSB+5];
  assign flags_o.h = data_i[LSB+4];
  assign prot_got  = data_i[LSB+3:LSB];

  assign prot_exp = {flags_o.v ^ flags_o.h,
                     flags_o.f ^ flags_o.h,
                     flags_o.f ^ flags_o.v,
                     flags_o.f ^ flags_o.v ^ flags_o.h};

  assign ok_o = data_i[LSB+7] && (prot_got == prot_exp);
endmodule

// File: rtl/tref_active_trk.sv
module tref_active_trk #(
  parameter int PH_N    = 4,
  parameter int PHASE_W = $clog2(PH_N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               ones_i,
  output logic               active_o,
  output logic [PHASE_W-1:0] phase_o
);
  localparam logic [PHASE_W-1:0] PH_LAST = PHASE_W'(PH_N - 1);

  logic               in_line_q;
  logic [PHASE_W-1:0] cnt_q;
  logic               take;

  assign take = in_line_q & ~ones_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_line_q <= 1'b0;
      cnt_q     <= '0;
      active_o  <= 1'b0;
      phase_o   <= '0;
    end else begin
      active_o <= take;
      phase_o  <= take ? cnt_q : '0;
      if (start_i) begin
        in_line_q <= 1'b1;
        cnt_q     <= '0;
      end else begin
        if (ones_i) in_line_q <= 1'b0;
        if (take)   cnt_q <= (cnt_q == PH_LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tref_decoder.sv
module tref_decoder #(
  parameter int DATA_W  = 8,
  parameter int PH_N    = 4,
  parameter int PHASE_W = $clog2(PH_N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  data_i,
  output logic               h_o,
  output logic               v_o,
  output logic               f_o,
  output logic               blank_o,
  output logic               active_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               err_o
);
  import tref_pkg::*;

  logic        stb, ones, ok, start;
  tref_flags_t dec, flg_q;

  tref_preamble_det #(.DATA_W(DATA_W)) u_det (
    .clk_i, .rst_ni, .data_i,
    .status_stb_o (stb),
    .ones_o       (ones)
  );

  tref_status_chk #(.DATA_W(DATA_W)) u_chk_st (
    .data_i,
    .flags_o (dec),
    .ok_o    (ok)
  );

  // line starts only on a clean start-of-active code outside vertical blanking
  assign start = stb & ok & ~dec.h & ~dec.v;

  tref_active_trk #(.PH_N(PH_N), .PHASE_W(PHASE_W)) u_trk (
    .clk_i, .rst_ni,
    .start_i  (start),
    .ones_i   (ones),
    .active_o (active_o),
    .phase_o  (phase_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= stb & ~ok;
      if (stb && ok) flg_q <= dec;
    end
  end

  assign h_o     = flg_q.h;
  assign v_o     = flg_q.v;
  assign f_o     = flg_q.f;
  assign blank_o = flg_q.h | flg_q.v;
endmodule

// File: rtl/tref_decoder_chk.sv
module tref_decoder_chk #(
  parameter int PHASE_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               h_o,
  input logic               v_o,
  input logic               f_o,
  input logic               active_o,
  input logic [PHASE_W-1:0] phase_o,
  input logic               err_o
);
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R3

  AST_ERR_HOLDS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable({h_o, v_o, f_o})); // R3

  AST_ACTIVE_IN_PICTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (!h_o && !v_o)); // R6

  AST_PHASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (phase_o == '0)); // R7

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && $past(active_o)) |-> (phase_o == PHASE_W'($past(phase_o) + 1'b1))); // R7

  AST_NO_ACTIVE_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$rose(active_o)); // R6
endmodule

bind tref_decoder tref_decoder_chk #(.PHASE_W(PHASE_W)) u_chk (.*);

// File: tb/sim_tref_decoder.sv
`timescale 1ns/1ps
module sim_tref_decoder;
  localparam int LINE_BYTES = 1440;
  localparam int FILL_BYTES = 268;
  localparam int WD_LIMIT   = 190000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       h_o, v_o, f_o, blank_o, active_o, err_o;
  logic [1:0] phase_o;

  tref_decoder u0 (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0, act_cnt = 0;
  logic       m_h, m_v, m_f, m_err, m_act, m_inl;
  logic [1:0] m_ph, m_cnt;
  logic [7:0] hist [3];

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [3:0] prot(logic f, logic v, logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [7:0] status(logic f, logic v, logic h);
    return {1'b1, f, v, h, prot(f, v, h)};
  endfunction

  task automatic model_reset();
    {m_h, m_v, m_f, m_err, m_act, m_inl} = '0;
    m_ph = 0; m_cnt = 0;
    foreach (hist[i]) hist[i] = 8'h00;
  endtask

  task automatic compare_all();
    check("R2 h_o", h_o, m_h);
    check("R2 v_o", v_o, m_v);
    check("R2 f_o", f_o, m_f);
    check("R3 err_o", err_o, m_err);
    check("R5 active_o", active_o, m_act);
    check("R7 phase_o", phase_o, m_ph);
    check("R8 blank_o", blank_o, m_h | m_v);
  endtask

  task automatic send(logic [7:0] b);
    logic is_st, ok, na;
    @(negedge clk_i);
    data_i = b;
    is_st = (hist[0] == 8'hFF) && (hist[1] == 8'h00) && (hist[2] == 8'h00);
    na = m_inl && (b != 8'hFF);
    m_ph = na ? m_cnt : 2'd0;
    if (na) m_cnt = m_cnt + 2'd1;
    m_act = na;
    if (na) act_cnt++;
    m_err = 1'b0;
    if (b == 8'hFF) m_inl = 1'b0;
    if (is_st) begin
      ok = b[7] && (b[3:0] == prot(b[6], b[5], b[4]));
      if (ok) begin
        m_f = b[6]; m_v = b[5]; m_h = b[4];
        if (!b[4] && !b[5]) begin m_inl = 1'b1; m_cnt = 2'd0; end
      end else m_err = 1'b1;
    end
    hist[0] = hist[1]; hist[1] = hist[2]; hist[2] = b;
    @(posedge clk_i);
    #1;
    compare_all();
  endtask

  task automatic send_code(logic [7:0] st);
    send(8'hFF); send(8'h00); send(8'h00); send(st);
  endtask

  task automatic send_fill(int n);
    for (int i = 0; i < n; i++) send(i[0] ? 8'h10 : 8'h80);
  endtask

  // one line: start code, payload, end code, horizontal filler
  task automatic send_line(logic f, logic v, logic bad_sav, logic broken);
    logic [7:0] st;
    int exp_cnt;
    st = status(f, v, 1'b0);
    if (bad_sav) st[$urandom_range(3, 0)] ^= 1'b1;
    if (broken) begin
      send(8'hFF); send(8'h00); send(8'h33); send(st);
      check("R4 h_o after broken preamble", h_o, m_h);
      check("R4 err_o after broken preamble", err_o, 0);
    end else send_code(st);
    exp_cnt = (!bad_sav && !broken && !v) ? LINE_BYTES : 0;
    act_cnt = 0;
    for (int i = 0; i < LINE_BYTES; i++)
      send(v ? (i[0] ? 8'h10 : 8'h80) : 8'($urandom_range(254, 1)));
    send(8'hFF);
    if (v) check("R6 active count, blanking line", act_cnt, exp_cnt);
    else   check("R5 active count per line", act_cnt, exp_cnt);
    send(8'h00); send(8'h00); send(status(f, v, 1'b1));
    send_fill(FILL_BYTES);
    check("R10 active_o after filler", active_o, 0);
    check("R10 h_o after filler", h_o, 1);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    model_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    compare_all();
    check("R1 reset blank_o", blank_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // directed: repeated 0xFF in preamble
    send(8'hFF); send_code(status(1'b1, 1'b0, 1'b1));
    check("R9 f_o after FF FF 00 00", f_o, 1);
    check("R9 h_o after FF FF 00 00", h_o, 1);
    // directed: bit7 cleared with correct check bits
    send_code({1'b0, 3'b010, prot(1'b0, 1'b1, 1'b0)});
    check("R3 err_o on bit7 clear", err_o, 1);
    check("R3 v_o held", v_o, 0);
    send(8'h80);
    check("R3 err_o single cycle", err_o, 0);

    send_line(1'b0, 1'b0, 1'b0, 1'b0);
    send_line(1'b0, 1'b1, 1'b0, 1'b0);
    send_line(1'b1, 1'b0, 1'b1, 1'b0);
    send_line(1'b0, 1'b0, 1'b0, 1'b1);

    // directed: reset mid-line, then zeros without preamble
    send_code(status(1'b0, 1'b0, 1'b0));
    for (int i = 0; i < 37; i++) send(8'($urandom_range(254, 1)));
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_reset();
    @(posedge clk_i);
    #1;
    check("R1 active_o in reset", active_o, 0);
    check("R1 phase_o in reset", phase_o, 0);
    check("R1 h_o in reset", h_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    send(8'h00); send(8'h00); send(status(1'b1, 1'b1, 1'b1));
    check("R1 no decode without preamble", f_o, 0);

    for (int n = 0; n < 24; n++)
      send_line(1'($urandom_range(1, 0)), ($urandom_range(3, 0) == 0),
                ($urandom_range(5, 0) == 0), ($urandom_range(7, 0) == 0));

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule